// File: doc/BRIEF.md
# Spectral Component Mixer with Noise

This block produces a single test-stimulus bit-stream for one input of a circuit under test in a sequential self-test setup. Upstream generators deliver a handful of Walsh waveform bits and one weighted pseudo-random bit. The mixer first applies a per-component phase, which may invert a component. It then time-shares the chosen sources in fixed proportions and can finally flip the chosen bit with a noise bit. The result is registered and advances only on the self-test clock enable.

The proportions are set by a 2-bit slot counter. In two-source mode, slots A and B alternate, so each source gets half the cycles. In three-source mode, the order is A, B, C, C: sources A and B get a quarter each and source C gets half. Each slot has its own selector. A selector picks one of the phased components, the weighted random bit, or a constant zero.

Top module: `spectral_mixer`

## Requirements
- R1: After the active-low asynchronous reset, stream_o is 0 and the slot counter is at slot A. The first enabled update therefore uses the slot A selector.
- R2: While en_i is 0, stream_o holds its value whatever the other inputs do.
- R3: With three_mode_i = 0, successive enabled updates take their source from the selectors in the order A, B, A, B, …
- R4: With three_mode_i = 1, successive enabled updates take their source from the selectors in the order A, B, C, C, repeating.
- R5: A component picked by selector value k < NCOMP contributes comp_i[k] XOR phase_i[k], so phase_i[k] = 1 inverts it.
- R6: Selector value NCOMP picks wrnd_i, and phase flags have no effect on it. A selector value above NCOMP yields 0.
- R7: When noise_en_i = 1, the registered bit is the selected bit XOR noise_i. When noise_en_i = 0, noise_i has no effect.
- R8: The slot counter advances by one on each enabled cycle only. Cycles with en_i = 0 do not skip a slot.
- R9: stream_o shows, one clock edge later, the result of the inputs present at the enabled edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Self-test clock enable |
| three_mode_i | input | 1 | 0: two sources A/B at 1/2 each; 1: A,B at 1/4, C at 1/2 |
| sel_a_i | input | SRC_W | Source index for slot A |
| sel_b_i | input | SRC_W | Source index for slot B |
| sel_c_i | input | SRC_W | Source index for slot C |
| comp_i | input | NCOMP | Walsh component bits |
| phase_i | input | NCOMP | Per-component inversion flags |
| wrnd_i | input | 1 | Weighted pseudo-random bit |
| noise_i | input | 1 | Noise bit |
| noise_en_i | input | 1 | Enables noise insertion |
| stream_o | output | 1 | Registered output stream bit |

## Verification
Phase inversion and noise insertion can act on the same bit in the same enabled cycle. When both flip it, the two inversions cancel. A directed task sets a component's phase flag, noise_en_i and noise_i to 1 at once. It expects the raw component value at the output. It then clears each flag in turn and expects a single inversion. A second overlap occurs when a stall falls between slots. The task checks that the held output and the next slot's source both stay correct across the stall.

// File: rtl/mix_pkg.sv
package mix_pkg;
  typedef enum logic [1:0] {
    SLOT_A = 2'd0,
    SLOT_B = 2'd1,
    SLOT_C = 2'd2
  } slot_e;
endpackage

// File: rtl/mix_phase.sv
module mix_phase #(
  parameter int NCOMP = 4,
  localparam int NSRC = NCOMP + 1
) (
  input  logic [NCOMP-1:0] comp_i,
  input  logic [NCOMP-1:0] phase_i,
  input  logic             wrnd_i,
  output logic [NSRC-1:0]  src_o
);
  for (genvar g = 0; g < NCOMP; g++) begin : g_ph
    assign src_o[g] = comp_i[g] ^ phase_i[g];
  end
  // weighted random source sits after the components, no phase
  assign src_o[NCOMP] = wrnd_i;
endmodule

// File: rtl/mix_slot.sv
module mix_slot
  import mix_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  en_i,
  input  logic  three_mode_i,
  output slot_e slot_o
);
  logic [1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= 2'd0;
    else if (en_i) cnt_q <= cnt_q + 2'd1;
  end

  always_comb begin
    if (three_mode_i && cnt_q[1]) slot_o = SLOT_C;
    else if (cnt_q[0])            slot_o = SLOT_B;
    else                          slot_o = SLOT_A;
  end

  a_r8_slot_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(cnt_q));
  a_r8_slot_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> cnt_q == $past(cnt_q) + 2'd1);
endmodule

// File: rtl/mix_select.sv
module mix_select
  import mix_pkg::*;
#(
  parameter int NCOMP = 4,
  localparam int NSRC  = NCOMP + 1,
  localparam int SRC_W = $clog2(NSRC)
) (
  input  slot_e            slot_i,
  input  logic [SRC_W-1:0] sel_a_i,
  input  logic [SRC_W-1:0] sel_b_i,
  input  logic [SRC_W-1:0] sel_c_i,
  input  logic [NSRC-1:0]  src_i,
  output logic             bit_o
);
  logic [SRC_W-1:0] sel;

  always_comb begin
    unique case (slot_i)
      SLOT_B:  sel = sel_b_i;
      SLOT_C:  sel = sel_c_i;
      default: sel = sel_a_i;
    endcase
  end

  // out-of-range selector falls through to 0
  always_comb begin
    bit_o = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (sel == SRC_W'(i)) bit_o = src_i[i];
    end
  end
endmodule

// File: rtl/mix_noise.sv
module mix_noise (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic mix_i,
  input  logic noise_i,
  input  logic noise_en_i,
  output logic stream_o
);
  logic stream_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   stream_q <= 1'b0;
    else if (en_i) stream_q <= mix_i ^ (noise_en_i & noise_i);
  end

  assign stream_o = stream_q;

  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(stream_q));
  a_r7_noise_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !noise_en_i |=> stream_q == $past(mix_i));
endmodule

// File: rtl/spectral_mixer.sv
module spectral_mixer
  import mix_pkg::*;
#(
  parameter int NCOMP = 4,
  localparam int NSRC  = NCOMP + 1,
  localparam int SRC_W = $clog2(NSRC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             three_mode_i,
  input  logic [SRC_W-1:0] sel_a_i,
  input  logic [SRC_W-1:0] sel_b_i,
  input  logic [SRC_W-1:0] sel_c_i,
  input  logic [NCOMP-1:0] comp_i,
  input  logic [NCOMP-1:0] phase_i,
  input  logic             wrnd_i,
  input  logic             noise_i,
  input  logic             noise_en_i,
  output logic             stream_o
);
  logic [NSRC-1:0] src;
  slot_e           slot;
  logic            mix;

  mix_phase #(.NCOMP(NCOMP)) u_phase (
    .comp_i (comp_i),
    .phase_i(phase_i),
    .wrnd_i (wrnd_i),
    .src_o  (src)
  );

  mix_slot u_slot (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .three_mode_i(three_mode_i),
    .slot_o      (slot)
  );

  mix_select #(.NCOMP(NCOMP)) u_sel (
    .slot_i (slot),
    .sel_a_i(sel_a_i),
    .sel_b_i(sel_b_i),
    .sel_c_i(sel_c_i),
    .src_i  (src),
    .bit_o  (mix)
  );

  mix_noise u_noise (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .mix_i     (mix),
    .noise_i   (noise_i),
    .noise_en_i(noise_en_i),
    .stream_o  (stream_o)
  );

  a_r6_wrnd_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !noise_en_i && slot == SLOT_A && sel_a_i == SRC_W'(NCOMP)
    |=> stream_o == $past(wrnd_i));
  a_r6_high_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !noise_en_i && slot == SLOT_A && sel_a_i > SRC_W'(NCOMP)
    |=> !stream_o);
  a_r4_c_wrnd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !noise_en_i && slot == SLOT_C && sel_c_i == SRC_W'(NCOMP)
    |=> stream_o == $past(wrnd_i));
  a_r3_no_c: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !three_mode_i |-> slot != SLOT_C);
endmodule

// File: tb/sim_spectral_mixer.sv
module sim_spectral_mixer;
  localparam int NCOMP = 4;
  localparam int SRC_W = 3;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             en = 1'b0;
  logic             three = 1'b0;
  logic [SRC_W-1:0] sa = '0, sb = '0, sc = '0;
  logic [NCOMP-1:0] comp = '0, phase = '0;
  logic             wrnd = 1'b0, noise = 1'b0, noise_en = 1'b0;
  logic             stream;

  int tests = 0, fails = 0, bslot = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  spectral_mixer #(.NCOMP(NCOMP)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .three_mode_i(three),
    .sel_a_i(sa), .sel_b_i(sb), .sel_c_i(sc), .comp_i(comp),
    .phase_i(phase), .wrnd_i(wrnd), .noise_i(noise),
    .noise_en_i(noise_en), .stream_o(stream)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: stream_o=%b expected %b", req, act, exp);
    end
  endtask

  function automatic logic src_bit(input logic [SRC_W-1:0] s);
    if (s < NCOMP)       return comp[s] ^ phase[s];
    else if (s == NCOMP) return wrnd;
    else                 return 1'b0;
  endfunction

  function automatic logic model_bit();
    logic [SRC_W-1:0] s;
    if (three && bslot >= 2) s = sc;
    else if (bslot % 2 == 1) s = sb;
    else                     s = sa;
    return src_bit(s) ^ (noise_en & noise);
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; en = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    bslot = 0;
  endtask

  // one enabled edge; inputs already set at a negedge
  task automatic step(input string req);
    logic exp;
    exp = model_bit();
    en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    en = 1'b0;
    bslot = (bslot + 1) % 4;
    chk(req, stream, exp);
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 reset value", stream, 1'b0);
    do_reset();
    three = 1'b0; comp = 4'b0001; phase = '0; sa = 3'd0; sb = 3'd1;
    step("R1 first update uses slot A");
  endtask

  task automatic t_two();
    do_reset();
    three = 1'b0; noise_en = 1'b0; phase = '0;
    comp = 4'b0101; sa = 3'd1; sb = 3'd2;
    for (int i = 0; i < 6; i++) step("R3 two-source A/B order");
    comp = 4'b1010;
    for (int i = 0; i < 4; i++) step("R3 two-source other pattern");
  endtask

  task automatic t_three();
    do_reset();
    three = 1'b1; noise_en = 1'b0; phase = '0;
    comp = 4'b0110; sa = 3'd0; sb = 3'd3; sc = 3'd1;
    for (int i = 0; i < 8; i++) step("R4 three-source A,B,C,C order");
    comp = 4'b1001; sc = 3'd2;
    for (int i = 0; i < 4; i++) step("R4 three-source second pattern");
    three = 1'b0;
  endtask

  task automatic t_phase();
    do_reset();
    three = 1'b0; noise_en = 1'b0;
    comp = 4'b0100; sa = 3'd2; sb = 3'd2;
    phase = 4'b0100; step("R5 phase inverts 1");
    comp = 4'b0000;  step("R5 phase inverts 0");
    phase = 4'b1011; step("R5 other phase flags ignored");
  endtask

  task automatic t_src();
    do_reset();
    three = 1'b0; noise_en = 1'b0; phase = 4'b1111;
    sa = 3'd4; sb = 3'd7; comp = 4'b1111;
    wrnd = 1'b1; step("R6 wrnd selected, no phase");
    step("R6 selector above NCOMP gives 0");
    wrnd = 1'b0; step("R6 wrnd zero");
    sb = 3'd5; step("R6 selector 5 gives 0");
  endtask

  task automatic t_noise();
    do_reset();
    three = 1'b0; phase = '0; comp = 4'b0001; sa = 3'd0; sb = 3'd1;
    noise_en = 1'b0; noise = 1'b1; step("R7 noise ignored when disabled");
    noise_en = 1'b1; step("R7 noise flips");
    noise = 1'b0; step("R7 noise zero passes");
    noise_en = 1'b0;
  endtask

  task automatic t_hold();
    logic held;
    do_reset();
    three = 1'b0; phase = '0; noise_en = 1'b0;
    comp = 4'b0010; sa = 3'd1; sb = 3'd0;
    step("R9 update after enabled edge");
    held = stream;
    for (int i = 0; i < 3; i++) begin
      comp = ~comp; wrnd = ~wrnd; sa = 3'd4;
      @(posedge clk); @(negedge clk);
      chk("R2 hold while en low", stream, held);
    end
    comp = 4'b0001; sa = 3'd1;
    step("R8 stall does not skip slot B");
    step("R8 back to slot A");
  endtask

  task automatic t_overlap();
    do_reset();
    three = 1'b0; sa = 3'd3; sb = 3'd3; comp = 4'b1000;
    phase = 4'b1000; noise_en = 1'b1; noise = 1'b1;
    step("R5 R7 double inversion cancels");
    phase = 4'b0000; step("R7 noise only inverts");
    phase = 4'b1000; noise = 1'b0; step("R5 phase only inverts");
    noise_en = 1'b0;
  endtask

  initial begin
    t_reset();
    t_two();
    t_three();
    t_phase();
    t_src();
    t_noise();
    t_hold();
    t_overlap();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule